// File: doc/BRIEF.md
# Call-Traced Code Bank Switcher

This block sits on the cartridge side of an 8-bit processor bus and decides which 4 KB code bank, and from which memory (ROM or RAM), answers fetches in the cartridge window. The processor sees eight banks, one in each odd 4 KB region ($1000-$1FFF, $3000-$3FFF, up to $F000-$FFFF), and address bits A15-A13 name the bank. Software never touches a switch register to change banks. The block watches subroutine call and return traffic on the stack page and takes the new bank number from the high address byte that passes on the bus one cycle after a watched stack slot.

Two call depths are tracked. A level-1 event is an access to stack slot $01FE, which is the call made with the stack pointer at $FF or the matching return. A level-2 event is an access to $01FC. Each level has its own 8-bit source map with one bit per bank: 0 means ROM and 1 means RAM. Software writes these maps in zero page, and they can be read back at a mirror page. A new map value is not used until the next switch event, so the code that is running is never pulled away beneath the processor.

The outputs are the physical bank bits and a ROM or RAM select for the current cycle. The memories themselves sit outside the block.

Top module: `sbank_switch`

## Requirements
- R1: After reset the current bank is 7, its code source is ROM, and both source maps read back as 0.
- R2: A cycle with A12 low asserts neither rom_cs_o nor ram_cs_o.
- R3: A read cycle with A12 high asserts exactly one select: rom_cs_o when the current source is ROM (0), ram_cs_o when it is RAM (1). bank_o always shows the current bank.
- R4: A write cycle with A12 high asserts no select, so stores into the code window never land, whether the current source is ROM or RAM.
- R5: A bus access to $01FE arms a level-1 switch. Bits 7:5 of data_i in the following cycle become the new bank, and the new source is bit [bank] of the level-1 map. Both take effect from the cycle after that data cycle.
- R6: An access to $01FC does the same as R5, but the source comes from the level-2 map.
- R7: Writing either map changes neither the current bank nor the current source until a later switch event.
- R8: A read of $04F1 returns the level-1 map and a read of $04F0 returns the level-2 map on rd_data_o, with rd_en_o high. rd_en_o is low on every other cycle, including writes to those addresses.
- R9: A write cycle whose address matches $00F1 (or $00F0) under the mask $12FF (A12=0, A9=0, low byte) loads data_i into the level-1 (level-2) map. The mirror $04F1 is an example of such an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | One clock per bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| data_i | input | 8 | Processor data bus value in this cycle |
| rw_i | input | 1 | 1 = read, 0 = write |
| bank_o | output | 3 | Current physical bank number |
| rom_cs_o | output | 1 | ROM select for this cycle |
| ram_cs_o | output | 1 | RAM select for this cycle |
| rd_data_o | output | 8 | Map readback value |
| rd_en_o | output | 1 | Drive rd_data_o onto the bus |

## Verification
Two things can happen in the same cycle: the armed latch that picks a new bank and source, and a fetch that is still served from the old bank. The high operand byte of a call is read from the caller's bank in exactly the cycle when the new bank number is captured. The bench replays call and return sequences cycle by cycle and checks that the select on that capture cycle still follows the old source, while the next cycle follows the new one. It also checks that a map bit changed just before the call is the one that is applied.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  typedef enum logic {
    SRC_ROM = 1'b0,
    SRC_RAM = 1'b1
  } code_src_e;
endpackage

// File: rtl/sbank_maps.sv
module sbank_maps #(
  parameter int          AW          = 16,
  parameter int          DW          = 8,
  parameter int          NB          = 8,
  parameter int          NLVL        = 2,
  parameter logic [7:0]  HS_BASE     = 8'hF1,  // level n at HS_BASE - n
  parameter logic [7:0]  MIRROR_PAGE = 8'h04
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic                rw_i,
  output logic [NLVL*NB-1:0]  maps_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                rd_en_o
);
  localparam logic [AW-1:0] WR_MASK = AW'(16'h12FF);

  logic [NLVL-1:0]  rd_hit;
  logic [DW-1:0]    rd_val [NLVL];

  for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
    localparam logic [7:0]    HS    = HS_BASE - 8'(lv);
    localparam logic [AW-1:0] WR_AT = AW'(HS);
    localparam logic [AW-1:0] RD_AT = AW'({MIRROR_PAGE, HS});
    logic [NB-1:0] map_q;
    logic          wr_hit;

    assign wr_hit = !rw_i && ((addr_i & WR_MASK) == WR_AT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     map_q <= '0;
      else if (wr_hit) map_q <= data_i[NB-1:0];
    end

    assign rd_hit[lv]              = rw_i && (addr_i == RD_AT);
    assign rd_val[lv]              = DW'(map_q);
    assign maps_o[lv*NB +: NB]     = map_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int lv = 0; lv < NLVL; lv++)
      if (rd_hit[lv]) rd_data_o = rd_val[lv];
  end
  assign rd_en_o = |rd_hit;
endmodule

// File: rtl/sbank_snoop.sv
module sbank_snoop
  import sbank_pkg::*;
#(
  parameter int              AW      = 16,
  parameter int              NB      = 8,
  parameter int              BW      = $clog2(NB),
  parameter logic [AW-1:0]   SLOT_L1 = 16'h01FE,
  parameter logic [AW-1:0]   SLOT_L2 = 16'h01FC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [BW-1:0]     hi_bits_i,
  input  logic [NB-1:0]     map_l1_i,
  input  logic [NB-1:0]     map_l2_i,
  output logic [BW-1:0]     bank_o,
  output code_src_e         src_o
);
  localparam logic [BW-1:0] RST_BANK = BW'(NB - 1);

  logic arm_l1_q, arm_l2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_l1_q <= 1'b0;
      arm_l2_q <= 1'b0;
      bank_o   <= RST_BANK;
      src_o    <= SRC_ROM;
    end else begin
      arm_l1_q <= (addr_i == SLOT_L1);
      arm_l2_q <= (addr_i == SLOT_L2);
      // map sampled at the switch, never earlier
      if (arm_l1_q) begin
        bank_o <= hi_bits_i;
        src_o  <= code_src_e'(map_l1_i[hi_bits_i]);
      end else if (arm_l2_q) begin
        bank_o <= hi_bits_i;
        src_o  <= code_src_e'(map_l2_i[hi_bits_i]);
      end
    end
  end
endmodule

// File: rtl/sbank_csel.sv
module sbank_csel
  import sbank_pkg::*;
(
  input  logic       cart_i,
  input  logic       rw_i,
  input  code_src_e  src_i,
  output logic       rom_cs_o,
  output logic       ram_cs_o
);
  logic fetch;
  assign fetch    = cart_i && rw_i;  // writes into the window are dropped
  assign rom_cs_o = fetch && (src_i == SRC_ROM);
  assign ram_cs_o = fetch && (src_i == SRC_RAM);
endmodule

// File: rtl/sbank_switch.sv
module sbank_switch
  import sbank_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              DW       = 8,
  parameter int              NB       = 8,
  parameter int              CART_BIT = 12,
  parameter logic [AW-1:0]   SLOT_L1  = 16'h01FE,
  parameter logic [AW-1:0]   SLOT_L2  = 16'h01FC,
  localparam int             BW       = $clog2(NB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  input  logic           rw_i,
  output logic [BW-1:0]  bank_o,
  output logic           rom_cs_o,
  output logic           ram_cs_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           rd_en_o
);
  localparam int NLVL = 2;

  logic [NLVL*NB-1:0] maps;
  code_src_e          src;

  sbank_maps #(.AW(AW), .DW(DW), .NB(NB), .NLVL(NLVL)) u_maps (
    .clk_i, .rst_ni, .addr_i, .data_i, .rw_i,
    .maps_o(maps), .rd_data_o, .rd_en_o
  );

  sbank_snoop #(.AW(AW), .NB(NB), .SLOT_L1(SLOT_L1), .SLOT_L2(SLOT_L2)) u_snoop (
    .clk_i, .rst_ni, .addr_i,
    .hi_bits_i(data_i[DW-1 -: BW]),
    .map_l1_i (maps[0 +: NB]),
    .map_l2_i (maps[NB +: NB]),
    .bank_o,
    .src_o    (src)
  );

  sbank_csel u_csel (
    .cart_i  (addr_i[CART_BIT]),
    .rw_i,
    .src_i   (src),
    .rom_cs_o,
    .ram_cs_o
  );
endmodule

// File: rtl/sbank_switch_chk.sv
module sbank_switch_chk #(
  parameter logic [15:0] SLOT_L1 = 16'h01FE,
  parameter logic [15:0] SLOT_L2 = 16'h01FC
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic        rw_i,
  input logic [2:0]  bank_o,
  input logic        rom_cs_o,
  input logic        ram_cs_o,
  input logic [7:0]  rd_data_o,
  input logic        rd_en_o
);
  // R2
  off_cart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[12] |-> (!rom_cs_o && !ram_cs_o));
  // R3
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[12] && rw_i) |-> ($countones({rom_cs_o, ram_cs_o}) == 1));
  // R4
  no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[12] && !rw_i) |-> (!rom_cs_o && !ram_cs_o));
  // R5
  l1_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SLOT_L1) |-> ##2 (bank_o == $past(data_i[7:5])));
  // R6
  l2_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SLOT_L2) |-> ##2 (bank_o == $past(data_i[7:5])));
  // R7
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(addr_i, 2) == SLOT_L1 || $past(addr_i, 2) == SLOT_L2) |-> $stable(bank_o));
  // R8
  readback_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rw_i && !addr_i[12] && addr_i[15:8] == 8'h04));
endmodule

bind sbank_switch sbank_switch_chk #(.SLOT_L1(SLOT_L1), .SLOT_L2(SLOT_L2)) u_chk (.*);

// File: tb/sbank_switch_bench.sv
module sbank_switch_bench;
  typedef struct {
    string      tag;
    logic [2:0] bank;
    logic       rom;
    logic       ram;
    logic       rden;
    logic [7:0] rd;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        rw_i = 1'b1;
  logic [2:0]  bank_o;
  logic        rom_cs_o, ram_cs_o, rd_en_o;
  logic [7:0]  rd_data_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  exp_t sb[$];

  // bench model of the requirements
  logic [2:0] m_bank = 3'd7;
  logic       m_ram  = 1'b0;
  logic [7:0] m_l1 = '0, m_l2 = '0;
  logic       m_arm1 = 1'b0, m_arm2 = 1'b0;

  always #5 clk_i = ~clk_i;

  sbank_switch u_sbank_switch (
    .clk_i, .rst_ni, .addr_i, .data_i, .rw_i,
    .bank_o, .rom_cs_o, .ram_cs_o, .rd_data_o, .rd_en_o
  );

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic rw, input string tag);
    exp_t e;
    @(negedge clk_i);
    addr_i = a; data_i = d; rw_i = rw;
    e.tag  = tag;
    e.bank = m_bank;
    e.rom  = a[12] && rw && !m_ram;
    e.ram  = a[12] && rw && m_ram;
    e.rden = rw && (a == 16'h04F1 || a == 16'h04F0);
    e.rd   = (a == 16'h04F1) ? m_l1 : m_l2;
    sb.push_back(e);
    // edge at the end of this cycle
    if (m_arm1) begin m_bank = d[7:5]; m_ram = m_l1[d[7:5]]; end
    else if (m_arm2) begin m_bank = d[7:5]; m_ram = m_l2[d[7:5]]; end
    m_arm1 = (a == 16'h01FE);
    m_arm2 = (a == 16'h01FC);
    if (!rw && ((a & 16'h12FF) == 16'h00F1)) m_l1 = d;
    if (!rw && ((a & 16'h12FF) == 16'h00F0)) m_l2 = d;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      exp_t e;
      @(negedge clk_i);
      #2;
      while (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (bank_o !== e.bank || rom_cs_o !== e.rom || ram_cs_o !== e.ram ||
            rd_en_o !== e.rden || (e.rden && rd_data_o !== e.rd)) begin
          failures++;
          $display("FAIL %s: bank=%0d rom=%b ram=%b rden=%b rd=%h expected bank=%0d rom=%b ram=%b rden=%b rd=%h",
                   e.tag, bank_o, rom_cs_o, ram_cs_o, rd_en_o, rd_data_o,
                   e.bank, e.rom, e.ram, e.rden, e.rd);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    cyc(16'hF000, 8'hEA, 1'b1, "R1 reset bank7 ROM");
    cyc(16'h04F1, 8'h00, 1'b1, "R1 level-1 map cleared");
    cyc(16'h04F0, 8'h00, 1'b1, "R1 level-2 map cleared");
    // R2 off-cart cycles
    cyc(16'h0080, 8'h00, 1'b1, "R2 zero-page read");
    cyc(16'h0F80, 8'h00, 1'b1, "R2 even region read");
    // R9 map writes, direct and mirror
    cyc(16'h00F1, 8'h84, 1'b0, "R9 write level-1 map");
    cyc(16'h04F0, 8'hF0, 1'b0, "R8 no readback on write");
    cyc(16'h04F1, 8'h00, 1'b1, "R8 R9 read level-1 map");
    cyc(16'h04F0, 8'h00, 1'b1, "R8 R9 read level-2 map via mirror write");
    // R7 bank 7 bit set in map, still ROM until a switch
    cyc(16'hF010, 8'h00, 1'b1, "R7 deferred source");
    cyc(16'h10F1, 8'h00, 1'b1, "R8 cart address not readback");
    // R4 store into code window while ROM
    cyc(16'hF020, 8'h55, 1'b0, "R4 store in ROM window");
    // level-1 call from bank 7 to bank 2 (map bit2 = 1 -> RAM)
    cyc(16'hF100, 8'h20, 1'b1, "R3 call opcode");
    cyc(16'hF101, 8'h00, 1'b1, "R3 call low operand");
    cyc(16'h01FF, 8'h00, 1'b1, "R2 stack dummy");
    cyc(16'h01FF, 8'hF1, 1'b0, "R2 push high");
    cyc(16'h01FE, 8'h02, 1'b0, "R5 push low arms level 1");
    cyc(16'hF102, 8'h50, 1'b1, "R5 capture cycle served from old bank");
    cyc(16'h5000, 8'h20, 1'b1, "R5 bank 2 from RAM");
    cyc(16'h5010, 8'h11, 1'b0, "R4 store in RAM window dropped");
    // level-2 call from bank 2 to bank 5 (level-2 map bit5 = 1 -> RAM)
    cyc(16'h01FD, 8'h50, 1'b0, "R2 push high level 2");
    cyc(16'h01FC, 8'h03, 1'b0, "R6 push low arms level 2");
    cyc(16'h5004, 8'hB0, 1'b1, "R6 capture cycle still bank 2 RAM");
    cyc(16'hB000, 8'hEA, 1'b1, "R6 bank 5 from RAM");
    // change level-1 map mid-flight; no effect yet
    cyc(16'h04F1, 8'h00, 1'b0, "R7 clear level-1 map");
    cyc(16'hB001, 8'hEA, 1'b1, "R7 bank 5 RAM kept");
    // level-2 return: pulls from $01FC then $01FD (caller high = bank 2, l2 bit2 = 0 -> ROM)
    cyc(16'h01FC, 8'h03, 1'b1, "R6 pull low arms level 2");
    cyc(16'h01FD, 8'h50, 1'b1, "R6 pull high");
    cyc(16'h5004, 8'hEA, 1'b1, "R6 return bank 2 from ROM");
    // level-1 return to bank 7 with new map (bit7 = 0 -> ROM)
    cyc(16'h01FE, 8'h02, 1'b1, "R5 pull low arms level 1");
    cyc(16'h01FF, 8'hF1, 1'b1, "R5 pull high");
    cyc(16'hF103, 8'hEA, 1'b1, "R5 return bank 7 ROM with updated map");
    // set bit7 again, switch via level 1 to bank 7 -> RAM
    cyc(16'h04F1, 8'h80, 1'b0, "R9 mirror write level-1");
    cyc(16'h01FE, 8'h00, 1'b1, "R5 arm again");
    cyc(16'h01FF, 8'hE0, 1'b1, "R5 high bank 7");
    cyc(16'hF200, 8'hEA, 1'b1, "R5 bank 7 from RAM");
    cyc(16'h04F1, 8'h00, 1'b1, "R8 readback after update");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule